// File: doc/BRIEF.md
# Flash Word Programming Sequencer

This block programs a run of consecutive words in a parallel NOR flash without processor help. A single start pulse loads a base address and a word count. For each word the sequencer fetches the data from a source port indexed by word number and writes the three-cycle unlock and setup prefix followed by the data write. It then reads the target address repeatedly until the status bit shows that the device's internal program operation has ended. A final read-back compares the stored word with the intended data before the sequencer moves to the next address.

The first word that fails stops the job. A failure is a verify mismatch, a poll that runs out of tries, or a fault flag that is still set after one more status read. The block then raises an error flag and holds the failing address. A clean job ends with a done flag. Both flags stay set until the next start. All flash bus cycles come from one bus cycle engine with fixed, parameterised write-strobe and read-access windows.

Top module: `flash_word_prog`

## Requirements
- R1: Each word is written as four bus writes in this order: 0xAA to address 0x555, 0x55 to address 0x2AA, 0xA0 to address 0x555, then the data word to the target address.
- R2: After the data write the sequencer reads the target address. Programming counts as finished when bit 7 of the read value equals bit 7 of the written data.
- R3: If a status read has bit 5 set and is not finished, exactly one more status read follows. If that read is also not finished, the job stops with an error. If POLL_MAX status reads pass without finishing, the job also stops with an error.
- R4: After programming finishes, the target is read back once. Any bit that differs from the data stops the job with an error.
- R5: Words are programmed at base, base+1, ..., base+count-1, in that order, with source index 0 to count-1. done_o rises after the last word verifies. No word after a failing one is touched. A count of 0 gives done_o with no bus cycle.
- R6: done_o and err_o are never high together. Each holds until the next accepted start. err_addr_o holds the address of the failing word.
- R7: In each bus write, fl_we_no is low for exactly WE_LOW clocks. Each read samples fl_dq_i RD_WAIT clocks after fl_oe_no falls. fl_we_no and fl_oe_no are never low together.
- R8: A start pulse while a job is running is ignored.
- R9: In reset, fl_ce_no, fl_we_no and fl_oe_no are high and done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when no job is running |
| base_addr_i | input | AW | First target word address |
| word_cnt_i | input | CW | Number of words to program |
| src_idx_o | output | CW | Index of the word whose data is wanted |
| src_data_i | input | DW | Data for the word at src_idx_o |
| fl_addr_o | output | AW | Flash address |
| fl_dq_o | output | DW | Flash write data |
| fl_dq_oe_o | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | DW | Flash read data |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_we_no | output | 1 | Write strobe, active low |
| fl_oe_no | output | 1 | Output enable, active low |
| done_o | output | 1 | Job finished with all words verified |
| err_o | output | 1 | Job stopped on a failing word |
| err_addr_o | output | AW | Address of the failing word |

## Verification
The bench drives a behavioural flash model and runs clean jobs of random length and data. These show whether the unlock order, the address stepping and the bit-7 completion test are right, because the model rejects any write out of sequence and reports it. Four fault kinds are placed at chosen words. A stuck data bit separates the verify path from the poll path. A device that never finishes exercises the poll limit. A fault flag followed by completion checks that a re-read happens. A fault flag with no completion checks that the re-read leads to an error. The model returns junk data until the read access window has passed, so a read sampled too early fails. Directed cases cover a zero count, a single word and a start pulse in the middle of a job.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {B_IDLE, B_ACT, B_REC} bus_state_e;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_SETUP, S_PGM,
    S_POLL, S_RECHK, S_VERIFY, S_NEXT, S_DONE, S_ERR
  } seq_state_e;

  localparam logic [11:0] UNL_ADDR_A = 12'h555;
  localparam logic [11:0] UNL_ADDR_B = 12'h2AA;
  localparam logic [7:0]  UNL_DATA_A = 8'hAA;
  localparam logic [7:0]  UNL_DATA_B = 8'h55;
  localparam logic [7:0]  PGM_CMD    = 8'hA0;
endpackage

// File: rtl/fwp_bus.sv
module fwp_bus
  import fwp_pkg::*;
#(
  parameter int AW      = 20,
  parameter int DW      = 16,
  parameter int WE_LOW  = 2,
  parameter int RD_WAIT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          idle_o,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [DW-1:0] fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no
);
  localparam int MAXW  = (WE_LOW > RD_WAIT) ? WE_LOW : RD_WAIT;
  localparam int CNT_W = $clog2(MAXW + 1);

  bus_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic [CNT_W-1:0] lim;

  assign lim    = wr_q ? CNT_W'(WE_LOW - 1) : CNT_W'(RD_WAIT - 1);
  assign idle_o = (st_q == B_IDLE);
  assign ack_o  = (st_q == B_REC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= B_IDLE;
      cnt_q      <= '0;
      wr_q       <= 1'b0;
      rdata_o    <= '0;
      fl_addr_o  <= '0;
      fl_dq_o    <= '0;
      fl_dq_oe_o <= 1'b0;
      fl_ce_no   <= 1'b1;
      fl_we_no   <= 1'b1;
      fl_oe_no   <= 1'b1;
    end else begin
      unique case (st_q)
        B_IDLE: if (req_i) begin
          st_q       <= B_ACT;
          cnt_q      <= '0;
          wr_q       <= wr_i;
          fl_addr_o  <= addr_i;
          fl_dq_o    <= wdata_i;
          fl_dq_oe_o <= wr_i;
          fl_ce_no   <= 1'b0;
          fl_we_no   <= !wr_i;
          fl_oe_no   <= wr_i;
        end
        B_ACT: begin
          if (cnt_q == lim) begin
            st_q     <= B_REC;
            fl_we_no <= 1'b1;
            fl_oe_no <= 1'b1;
            if (!wr_q) rdata_o <= fl_dq_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        B_REC: begin
          st_q       <= B_IDLE;
          fl_ce_no   <= 1'b1;
          fl_dq_oe_o <= 1'b0;
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  // R7
  we_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> ($past(fl_we_no) == 1'b0) && ($past(fl_we_no, 2) == 1'b0));
  // R7
  no_oe_we_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_no && !fl_oe_no));
  // R7
  ce_during_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no || !fl_oe_no) |-> !fl_ce_no);
endmodule

// File: rtl/fwp_poll_eval.sv
module fwp_poll_eval #(
  parameter int DW        = 16,
  parameter int DONE_BIT  = 7,
  parameter int FAULT_BIT = 5
) (
  input  logic [DW-1:0] status_i,
  input  logic          want_i,
  output logic          finished_o,
  output logic          fault_o
);
  assign finished_o = (status_i[DONE_BIT] == want_i);
  assign fault_o    = status_i[FAULT_BIT];
endmodule

// File: rtl/flash_word_prog.sv
module flash_word_prog
  import fwp_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int CW       = 12,
  parameter int WE_LOW   = 2,
  parameter int RD_WAIT  = 2,
  parameter int POLL_MAX = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] word_cnt_i,
  output logic [CW-1:0] src_idx_o,
  input  logic [DW-1:0] src_data_i,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [DW-1:0] fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] err_addr_o
);
  localparam int PW = $clog2(POLL_MAX + 1);

  seq_state_e    st_q;
  logic          pend_q;
  logic [CW-1:0] idx_q, cnt_q;
  logic [AW-1:0] base_q, cur_addr;
  logic [DW-1:0] wdata_q;
  logic [PW-1:0] poll_q;

  logic          op_st, req, op_wr, bus_idle, bus_ack, finished, fault;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata, rdata;
  logic          can_start;

  assign cur_addr  = base_q + AW'(idx_q);
  assign src_idx_o = idx_q;
  assign done_o    = (st_q == S_DONE);
  assign err_o     = (st_q == S_ERR);
  assign can_start = (st_q == S_IDLE) || (st_q == S_DONE) || (st_q == S_ERR);

  always_comb begin
    op_st    = 1'b1;
    op_wr    = 1'b0;
    op_addr  = cur_addr;
    op_wdata = wdata_q;
    unique case (st_q)
      S_UNL1:  begin op_wr = 1'b1; op_addr = AW'(UNL_ADDR_A); op_wdata = DW'(UNL_DATA_A); end
      S_UNL2:  begin op_wr = 1'b1; op_addr = AW'(UNL_ADDR_B); op_wdata = DW'(UNL_DATA_B); end
      S_SETUP: begin op_wr = 1'b1; op_addr = AW'(UNL_ADDR_A); op_wdata = DW'(PGM_CMD);    end
      S_PGM:   op_wr = 1'b1;
      S_POLL, S_RECHK, S_VERIFY: op_wr = 1'b0;
      default: op_st = 1'b0;
    endcase
  end

  assign req = op_st && !pend_q;

  fwp_bus #(.AW(AW), .DW(DW), .WE_LOW(WE_LOW), .RD_WAIT(RD_WAIT)) u_bus (
    .clk_i, .rst_ni,
    .req_i(req), .wr_i(op_wr), .addr_i(op_addr), .wdata_i(op_wdata),
    .idle_o(bus_idle), .ack_o(bus_ack), .rdata_o(rdata),
    .fl_addr_o, .fl_dq_o, .fl_dq_oe_o, .fl_dq_i,
    .fl_ce_no, .fl_we_no, .fl_oe_no
  );

  fwp_poll_eval #(.DW(DW)) u_eval (
    .status_i(rdata), .want_i(wdata_q[7]),
    .finished_o(finished), .fault_o(fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      pend_q     <= 1'b0;
      idx_q      <= '0;
      cnt_q      <= '0;
      base_q     <= '0;
      wdata_q    <= '0;
      poll_q     <= '0;
      err_addr_o <= '0;
    end else if (start_i && can_start) begin
      base_q <= base_addr_i;
      cnt_q  <= word_cnt_i;
      idx_q  <= '0;
      pend_q <= 1'b0;
      poll_q <= '0;
      st_q   <= (word_cnt_i == '0) ? S_DONE : S_UNL1;
    end else if (op_st) begin
      if (req && bus_idle) begin
        pend_q <= 1'b1;
        if (st_q == S_UNL1) wdata_q <= src_data_i;
      end
      if (pend_q && bus_ack) begin
        pend_q <= 1'b0;
        unique case (st_q)
          S_UNL1:  st_q <= S_UNL2;
          S_UNL2:  st_q <= S_SETUP;
          S_SETUP: st_q <= S_PGM;
          S_PGM: begin
            st_q   <= S_POLL;
            poll_q <= '0;
          end
          S_POLL: begin
            if (finished)                         st_q <= S_VERIFY;
            else if (fault)                       st_q <= S_RECHK;
            else if (poll_q == PW'(POLL_MAX - 1)) begin
              st_q       <= S_ERR;
              err_addr_o <= cur_addr;
            end else poll_q <= poll_q + 1'b1;
          end
          S_RECHK: begin
            if (finished) st_q <= S_VERIFY;
            else begin
              st_q       <= S_ERR;
              err_addr_o <= cur_addr;
            end
          end
          S_VERIFY: begin
            if (rdata == wdata_q) st_q <= S_NEXT;
            else begin
              st_q       <= S_ERR;
              err_addr_o <= cur_addr;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end else if (st_q == S_NEXT) begin
      if (idx_q == cnt_q - 1'b1) st_q <= S_DONE;
      else begin
        idx_q <= idx_q + 1'b1;
        st_q  <= S_UNL1;
      end
    end
  end

  // R6
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  // R3
  poll_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PW'(POLL_MAX));
  // R5
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_st |-> (idx_q < cnt_q));
  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !can_start) |=> $stable(base_q) && $stable(cnt_q));
  // R6
  err_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_o) && err_o) |-> $stable(err_addr_o));
endmodule

// File: tb/flash_word_prog_tb_top.sv
`timescale 1ns/1ps
module flash_word_prog_tb_top;
  localparam int AW = 20, DW = 16, CW = 12;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] word_cnt = '0;
  logic [CW-1:0] src_idx;
  logic [DW-1:0] src_data;
  logic [AW-1:0] fl_addr, err_addr;
  logic [DW-1:0] fl_dq_o, fl_dq_i;
  logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, done, err;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  flash_word_prog dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base_addr),
    .word_cnt_i(word_cnt), .src_idx_o(src_idx), .src_data_i(src_data),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_no(fl_ce_n), .fl_we_no(fl_we_n), .fl_oe_no(fl_oe_n),
    .done_o(done), .err_o(err), .err_addr_o(err_addr)
  );

  function automatic logic [15:0] pat(input logic [15:0] key, input int i);
    logic [15:0] v;
    v = 16'(i * 40503) ^ key ^ 16'(i << 7);
    return v;
  endfunction

  logic [15:0] cur_key = '0;
  assign src_data = pat(cur_key, int'(src_idx));

  // flash model; fault kinds: 0 none, 1 bit0 stuck low, 2 never finishes,
  // 3 fault flag then finishes, 4 fault flag and never finishes
  int            fkind = 0;
  logic [AW-1:0] faddr = '0, job_base = '0;
  logic          clr = 1'b0;
  logic [15:0]   mem [256];
  int            busy_cnt = 0, oe_cnt = 0, we_lo = 0, we_min = 1000;
  int            seq_err = 0, order_err = 0, ce_falls = 0, overlap = 0;
  logic          hang = 0, d5f = 0, d7w = 0, tog = 0;
  logic          we_prev = 1, oe_prev = 1, ce_prev = 1;
  logic [1:0]    cst = 0;
  logic [AW-1:0] exp_next = '0;

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'hFFFF;
      busy_cnt <= 0; hang <= 0; d5f <= 0; cst <= 0; we_lo <= 0; we_min <= 1000;
      seq_err <= 0; order_err <= 0; ce_falls <= 0; overlap <= 0; exp_next <= job_base;
    end else begin
      if (!fl_we_n && !fl_oe_n) overlap <= overlap + 1;
      if (ce_prev && !fl_ce_n) ce_falls <= ce_falls + 1;
      if (!fl_we_n) we_lo <= we_lo + 1;
      if (busy_cnt > 0 && !hang) busy_cnt <= busy_cnt - 1;
      if (!we_prev && fl_we_n) begin
        if (we_lo < we_min) we_min <= we_lo;
        we_lo <= 0;
        if (busy_cnt > 0) seq_err <= seq_err + 1;
        case (cst)
          2'd0: if (fl_addr == 20'h555 && fl_dq_o == 16'hAA) cst <= 2'd1;
                else seq_err <= seq_err + 1;
          2'd1: if (fl_addr == 20'h2AA && fl_dq_o == 16'h55) cst <= 2'd2;
                else begin seq_err <= seq_err + 1; cst <= 2'd0; end
          2'd2: if (fl_addr == 20'h555 && fl_dq_o == 16'hA0) cst <= 2'd3;
                else begin seq_err <= seq_err + 1; cst <= 2'd0; end
          default: begin
            cst <= 2'd0;
            if (fl_addr != exp_next) order_err <= order_err + 1;
            exp_next <= fl_addr + 1'b1;
            mem[fl_addr[7:0]] <= (fkind == 1 && fl_addr == faddr) ? (fl_dq_o & 16'hFFFE) : fl_dq_o;
            d7w  <= fl_dq_o[7];
            hang <= (fkind == 2 || fkind == 4) && fl_addr == faddr;
            d5f  <= (fkind == 3 || fkind == 4) && fl_addr == faddr;
            busy_cnt <= (fkind == 3 && fl_addr == faddr) ? 1000 : 1 + int'($urandom % 6);
          end
        endcase
      end
      if (!oe_prev && fl_oe_n) begin
        tog <= ~tog;
        if (busy_cnt > 0 && d5f && fkind == 3) busy_cnt <= 0;
      end
    end
    oe_cnt  <= fl_oe_n ? 0 : oe_cnt + 1;
    we_prev <= fl_we_n;
    oe_prev <= fl_oe_n;
    ce_prev <= fl_ce_n;
  end

  always_comb begin
    fl_dq_i = 16'h5A3C;
    if (!fl_ce_n && !fl_oe_n && oe_cnt >= 1) begin
      if (busy_cnt > 0) begin
        fl_dq_i = '0;
        fl_dq_i[7] = ~d7w;
        fl_dq_i[6] = tog;
        fl_dq_i[5] = d5f;
      end else fl_dq_i = mem[fl_addr[7:0]];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_job(input logic [AW-1:0] base, input int cnt, input int kind,
                         input int fidx, input logic [15:0] key, input bit poke);
    int fail_i, t, bad, stop;
    logic [15:0] d;
    string req;
    fkind = kind; faddr = base + AW'(fidx); cur_key = key; job_base = base;
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    base_addr = base; word_cnt = CW'(cnt); start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      base_addr = base + 20'd5; word_cnt = 12'd3; start = 1'b1;  // R8
      @(negedge clk) start = 1'b0;
      base_addr = base;
    end
    t = 0;
    while (!(done || err) && t < 30000) begin @(negedge clk); t++; end
    check(t < 30000, "R5", "job finishes before watchdog", t, 0);

    fail_i = -1;
    for (int i = 0; i < cnt; i++) begin
      d = pat(key, i);
      if ((kind == 1 && i == fidx && d[0]) || ((kind == 2 || kind == 4) && i == fidx)) begin
        fail_i = i; break;
      end
    end
    req = (kind == 1) ? "R4" : "R3";
    if (fail_i < 0) begin
      check(done && !err, "R5", "done without error", {done, err}, 2'b10);
    end else begin
      check(err && !done, req, "error on fault", {done, err}, 2'b01);
      check(err_addr == base + AW'(fail_i), "R6", "failing address", err_addr, base + AW'(fail_i));
    end
    stop = (fail_i < 0) ? cnt : fail_i;
    bad = 0;
    for (int i = 0; i < stop; i++)
      if (mem[8'(base + AW'(i))] != pat(key, i)) bad++;
    check(bad == 0, "R2", "programmed words match data", bad, 0);
    bad = 0;
    for (int i = stop + 1; i < cnt; i++)
      if (mem[8'(base + AW'(i))] != 16'hFFFF) bad++;
    check(bad == 0, "R5", "words after failure untouched", bad, 0);
    check(seq_err == 0, "R1", "command sequence errors", seq_err, 0);
    check(order_err == 0, "R5", "address order errors", order_err, 0);
    check(overlap == 0, "R7", "WE/OE overlap cycles", overlap, 0);
    if (cnt > 0) check(we_min == 2, "R7", "WE low width", we_min, 2);
    else check(ce_falls == 0, "R5", "no bus cycle on zero count", ce_falls, 0);
    repeat (5) @(negedge clk);
    check(done == (fail_i < 0) && err == (fail_i >= 0), "R6", "flags held",
          {done, err}, {fail_i < 0, fail_i >= 0});
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R9
    check(fl_ce_n && fl_we_n && fl_oe_n && !done && !err, "R9", "reset outputs",
          {fl_ce_n, fl_we_n, fl_oe_n, done, err}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    run_job(20'h40010, 5, 0, 0, 16'h1234, 0);
    run_job(20'h40080, 1, 0, 0, 16'hC3A5, 0);
    run_job(20'h40020, 0, 0, 0, 16'h0000, 0);
    run_job(20'h40030, 6, 1, 2, 16'h0001, 0);   // R4 stuck bit
    run_job(20'h40040, 4, 2, 1, 16'h7E7E, 0);   // R3 timeout
    run_job(20'h40050, 5, 3, 2, 16'h00FF, 0);   // R3 re-read finishes
    run_job(20'h40060, 5, 4, 3, 16'hFF00, 0);   // R3 re-read fails
    run_job(20'h40070, 8, 0, 0, 16'h5555, 1);   // R8
    for (int j = 0; j < 8; j++) begin
      int c;
      c = 1 + int'($urandom % 20);
      run_job(20'h40000 | AW'($urandom % 150), c, int'($urandom % 5),
              int'($urandom % c), 16'($urandom), 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule